// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between the line-side receiver of a UART, the CPU data register and the two byte FIFOs. Four channel modes decide where traffic goes. In normal mode, line bytes go to the receive FIFO and CPU writes go to the transmit FIFO. In echo mode, line bytes go to both FIFOs. In local loopback, CPU writes go to the receive FIFO. In remote loopback, line bytes go straight to the transmit FIFO. The FIFO storage and the serializer live outside the block. The block sees only their fill counts and the receive FIFO's head byte. It drives push and pop strobes back to them.

A control register holds a pair of enable and disable bits for each direction. It also holds two self-clearing flush bits, one per FIFO. A push that meets a full FIFO is dropped and raises a one-cycle overflow pulse. A line break is turned into a single zero byte on the receive side. A credit output tells the line side how many more bytes it can deliver in the current mode.

All steering outputs are combinational in the strobes of the same cycle. Only the control register is clocked.

Top module: `uart_chan_router`

## Requirements
- R1: A line byte (`line_vld_i`) is routed by `mode_i`. Mode 0 (normal) sends it to the receive FIFO. Mode 1 (echo) sends it to both FIFOs. Mode 2 (local loopback) sends it nowhere. Mode 3 (remote loopback) sends it to the transmit FIFO.
- R2: A CPU data write (`cpu_wr_i`) goes to the transmit FIFO in mode 0 and to the receive FIFO in mode 2. It is dropped in modes 1 and 3.
- R3: The receive path is on only when control bit 2 is 1 and control bit 3 is 0. The transmit path is on only when bit 4 is 1 and bit 5 is 0. A push toward a path that is off is dropped, with no push and no overflow pulse.
- R4: A push toward an enabled receive FIFO whose count equals its depth is discarded, and `rx_ovf_o` is high in that cycle.
- R5: A push toward an enabled transmit FIFO whose count equals its depth is discarded, and `tx_ovf_o` is high in that cycle.
- R6: A CPU data read with the receive path on and a non-empty FIFO pops one byte and returns the head byte. When the FIFO is empty or the path is off, the read returns 0 and pops nothing.
- R7: `line_credit_o` is the free receive space in mode 0 and the free transmit space in mode 3. In mode 1 it is the smaller of the two, and in mode 2 it is 0. Enables do not affect it.
- R8: `line_brk_i` pushes one zero byte toward the receive FIFO in every mode, subject to R3 and R4. Any line byte in the same cycle is ignored, and in mode 2 a CPU write in the same cycle is dropped.
- R9: Writing control bit 0 (bit 1) makes `rx_flush_o` (`tx_flush_o`) and that bit of `ctrl_o` high for exactly the cycle after the write, unless the write is repeated.
- R10: After reset, `ctrl_o` is 0x128, so both paths are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control register write value |
| ctrl_o | output | 9 | Control register contents |
| line_vld_i | input | 1 | Received byte strobe from line side |
| line_data_i | input | DATA_W | Received byte |
| line_brk_i | input | 1 | Break event from line side |
| cpu_wr_i | input | 1 | CPU data register write strobe |
| cpu_wdata_i | input | DATA_W | CPU write byte |
| cpu_rd_i | input | 1 | CPU data register read strobe |
| cpu_rdata_o | output | DATA_W | CPU read byte |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| tx_cnt_i | input | CNT_W | Transmit FIFO fill count |
| rx_head_i | input | DATA_W | Oldest byte in receive FIFO |
| rx_push_o | output | 1 | Receive FIFO push |
| rx_push_data_o | output | DATA_W | Receive FIFO push byte |
| tx_push_o | output | 1 | Transmit FIFO push |
| tx_push_data_o | output | DATA_W | Transmit FIFO push byte |
| rx_pop_o | output | 1 | Receive FIFO pop |
| rx_ovf_o | output | 1 | Receive overflow pulse |
| tx_ovf_o | output | 1 | Transmit overflow pulse |
| rx_flush_o | output | 1 | Receive FIFO flush pulse |
| tx_flush_o | output | 1 | Transmit FIFO flush pulse |
| line_credit_o | output | CNT_W | Bytes the line side may still deliver |

## Verification
The hardest state to reach from the ports is a collision in local loopback: a break arrives in the same cycle as a CPU write while the receive FIFO is full and a flush is pending. Reaching it needs a full FIFO, the right mode, the receive path enabled and two rare strobes at once.

The bench makes this reachable by overriding the FIFO depths to small, unequal values. It drains its transmit queue slowly and runs every mode in turn under several enable settings. Within each phase it fires break, write, read and flush strobes at independent rates, so full FIFOs and coinciding events recur in every mode.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LOCAL  = 2'd2,
    CM_REMOTE = 2'd3
  } chan_mode_e;

  localparam int CTRL_W = 9;
  localparam logic [CTRL_W-1:0] CTRL_RST = 9'h128;

  localparam int B_RX_FLUSH = 0;
  localparam int B_TX_FLUSH = 1;
  localparam int B_RX_EN    = 2;
  localparam int B_RX_DIS   = 3;
  localparam int B_TX_EN    = 4;
  localparam int B_TX_DIS   = 5;

  function automatic logic path_on(input logic en, input logic dis);
    return en & ~dis;
  endfunction
endpackage

// File: rtl/uart_route_ctrl.sv
module uart_route_ctrl
  import uart_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              rx_on_o,
  output logic              tx_on_o,
  output logic              rx_flush_o,
  output logic              tx_flush_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (we_i) begin
      ctrl_q <= wdata_i;
    end else begin
      ctrl_q[B_TX_FLUSH:B_RX_FLUSH] <= '0;  // flush bits self-clear
    end
  end

  assign ctrl_o     = ctrl_q;
  assign rx_on_o    = path_on(ctrl_q[B_RX_EN], ctrl_q[B_RX_DIS]);
  assign tx_on_o    = path_on(ctrl_q[B_TX_EN], ctrl_q[B_TX_DIS]);
  assign rx_flush_o = ctrl_q[B_RX_FLUSH];
  assign tx_flush_o = ctrl_q[B_TX_FLUSH];

  p_rx_flush_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flush_o && !we_i) |=> !rx_flush_o);
  p_tx_flush_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flush_o && !we_i) |=> !tx_flush_o);
  p_flush_from_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |=> !rx_flush_o && !tx_flush_o);
endmodule

// File: rtl/uart_route_gate.sv
module uart_route_gate #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             on_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             push_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic full;
  assign full   = (cnt_i >= FULL_CNT);
  assign push_o = req_i & on_i & ~full;
  assign ovf_o  = req_i & on_i & full;

  // R4 for the receive instance, R5 for the transmit instance
  p_push_room_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (cnt_i < FULL_CNT) && on_i);
  p_ovf_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !push_o && (cnt_i == FULL_CNT));
  p_off_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |-> !push_o && !ovf_o);
endmodule

// File: rtl/uart_route_steer.sv
module uart_route_steer
  import uart_route_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  chan_mode_e        mode_i,
  input  logic              rx_on_i,
  input  logic              tx_on_i,
  input  logic              line_vld_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              line_brk_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [DATA_W-1:0] rx_head_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_push_data_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_push_data_o,
  output logic              rx_pop_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              rx_ovf_o,
  output logic              tx_ovf_o
);
  logic line_to_rx, line_to_tx, cpu_to_rx, cpu_to_tx;
  logic rx_req, tx_req;

  always_comb begin
    line_to_rx = line_vld_i & ~line_brk_i & (mode_i == CM_NORMAL || mode_i == CM_ECHO);
    line_to_tx = line_vld_i & ~line_brk_i & (mode_i == CM_ECHO || mode_i == CM_REMOTE);
    cpu_to_rx  = cpu_wr_i & ~line_brk_i & (mode_i == CM_LOCAL);  // break owns the rx slot
    cpu_to_tx  = cpu_wr_i & (mode_i == CM_NORMAL);
    rx_req     = line_brk_i | line_to_rx | cpu_to_rx;
    tx_req     = line_to_tx | cpu_to_tx;

    if (line_brk_i)      rx_push_data_o = '0;
    else if (line_to_rx) rx_push_data_o = line_data_i;
    else                 rx_push_data_o = cpu_wdata_i;

    tx_push_data_o = cpu_to_tx ? cpu_wdata_i : line_data_i;
  end

  uart_route_gate #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_rx_gate (
    .clk_i, .rst_ni, .req_i(rx_req), .on_i(rx_on_i), .cnt_i(rx_cnt_i),
    .push_o(rx_push_o), .ovf_o(rx_ovf_o)
  );

  uart_route_gate #(.DEPTH(TX_DEPTH), .CNT_W(CNT_W)) u_tx_gate (
    .clk_i, .rst_ni, .req_i(tx_req), .on_i(tx_on_i), .cnt_i(tx_cnt_i),
    .push_o(tx_push_o), .ovf_o(tx_ovf_o)
  );

  assign rx_pop_o    = cpu_rd_i & rx_on_i & (rx_cnt_i != '0);
  assign cpu_rdata_o = rx_pop_o ? rx_head_i : '0;

  p_pop_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (rx_cnt_i != '0) && cpu_rd_i);
  p_empty_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && rx_cnt_i == '0) |-> (cpu_rdata_o == '0) && !rx_pop_o);
  p_cpu_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == CM_ECHO || mode_i == CM_REMOTE) && !line_vld_i && !line_brk_i)
      |-> !rx_push_o && !tx_push_o);
  p_local_no_tx_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_LOCAL) |-> !tx_push_o && !tx_ovf_o);
  p_brk_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_brk_i && rx_push_o) |-> (rx_push_data_o == '0));
endmodule

// File: rtl/uart_route_credit.sv
module uart_route_credit
  import uart_route_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int CNT_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  chan_mode_e       mode_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  output logic [CNT_W-1:0] credit_o
);
  localparam logic [CNT_W-1:0] RX_FULL = CNT_W'(RX_DEPTH);
  localparam logic [CNT_W-1:0] TX_FULL = CNT_W'(TX_DEPTH);

  logic [CNT_W-1:0] rx_free, tx_free;
  assign rx_free = (rx_cnt_i >= RX_FULL) ? '0 : RX_FULL - rx_cnt_i;
  assign tx_free = (tx_cnt_i >= TX_FULL) ? '0 : TX_FULL - tx_cnt_i;

  always_comb begin
    unique case (mode_i)
      CM_NORMAL: credit_o = rx_free;
      CM_ECHO:   credit_o = (rx_free < tx_free) ? rx_free : tx_free;
      CM_REMOTE: credit_o = tx_free;
      default:   credit_o = '0;
    endcase
  end

  p_credit_rx_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == CM_NORMAL || mode_i == CM_ECHO) && rx_cnt_i == RX_FULL) |-> credit_o == '0);
  p_credit_tx_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == CM_REMOTE || mode_i == CM_ECHO) && tx_cnt_i == TX_FULL) |-> credit_o == '0);
  p_credit_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_NORMAL && rx_cnt_i == '0) |-> credit_o == RX_FULL);
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_route_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 64,
  parameter int DATA_W   = 8,
  localparam int MAX_DEPTH = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              ctrl_we_i,
  input  logic [8:0]        ctrl_wdata_i,
  output logic [8:0]        ctrl_o,
  input  logic              line_vld_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              line_brk_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [DATA_W-1:0] rx_head_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_push_data_o,
  output logic              tx_push_o,
  output logic [DATA_W-1:0] tx_push_data_o,
  output logic              rx_pop_o,
  output logic              rx_ovf_o,
  output logic              tx_ovf_o,
  output logic              rx_flush_o,
  output logic              tx_flush_o,
  output logic [CNT_W-1:0]  line_credit_o
);
  chan_mode_e mode;
  logic       rx_on, tx_on;

  assign mode = chan_mode_e'(mode_i);

  uart_route_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .we_i(ctrl_we_i), .wdata_i(ctrl_wdata_i), .ctrl_o(ctrl_o),
    .rx_on_o(rx_on), .tx_on_o(tx_on),
    .rx_flush_o(rx_flush_o), .tx_flush_o(tx_flush_o)
  );

  uart_route_steer #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_steer (
    .clk_i, .rst_ni, .mode_i(mode), .rx_on_i(rx_on), .tx_on_i(tx_on),
    .line_vld_i, .line_data_i, .line_brk_i,
    .cpu_wr_i, .cpu_wdata_i, .cpu_rd_i,
    .rx_cnt_i, .tx_cnt_i, .rx_head_i,
    .rx_push_o, .rx_push_data_o, .tx_push_o, .tx_push_data_o,
    .rx_pop_o, .cpu_rdata_o, .rx_ovf_o, .tx_ovf_o
  );

  uart_route_credit #(
    .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .CNT_W(CNT_W)
  ) u_credit (
    .clk_i, .rst_ni, .mode_i(mode), .rx_cnt_i, .tx_cnt_i, .credit_o(line_credit_o)
  );

  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[B_RX_DIS] || !ctrl_o[B_RX_EN]) |-> !rx_push_o && !rx_pop_o && !rx_ovf_o);
  p_tx_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[B_TX_DIS] || !ctrl_o[B_TX_EN]) |-> !tx_push_o && !tx_ovf_o);
endmodule

// File: tb/uart_chan_router_bench.sv
`timescale 1ns/1ps
module uart_chan_router_bench;
  localparam int RXD = 4;
  localparam int TXD = 6;
  localparam int DW  = 8;
  localparam int CW  = $clog2(((RXD > TXD) ? RXD : TXD) + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]    mode_i = '0;
  logic          ctrl_we_i = 1'b0;
  logic [8:0]    ctrl_wdata_i = '0;
  logic [8:0]    ctrl_o;
  logic          line_vld_i = 1'b0, line_brk_i = 1'b0;
  logic [DW-1:0] line_data_i = '0;
  logic          cpu_wr_i = 1'b0, cpu_rd_i = 1'b0;
  logic [DW-1:0] cpu_wdata_i = '0, cpu_rdata_o;
  logic [CW-1:0] rx_cnt_i = '0, tx_cnt_i = '0, line_credit_o;
  logic [DW-1:0] rx_head_i = '0;
  logic          rx_push_o, tx_push_o, rx_pop_o, rx_ovf_o, tx_ovf_o, rx_flush_o, tx_flush_o;
  logic [DW-1:0] rx_push_data_o, tx_push_data_o;

  uart_chan_router #(.RX_DEPTH(RXD), .TX_DEPTH(TXD), .DATA_W(DW)) u_uart_chan_router (
    .clk_i(clk), .rst_ni, .mode_i, .ctrl_we_i, .ctrl_wdata_i, .ctrl_o,
    .line_vld_i, .line_data_i, .line_brk_i, .cpu_wr_i, .cpu_wdata_i, .cpu_rd_i,
    .cpu_rdata_o, .rx_cnt_i, .tx_cnt_i, .rx_head_i,
    .rx_push_o, .rx_push_data_o, .tx_push_o, .tx_push_data_o, .rx_pop_o,
    .rx_ovf_o, .tx_ovf_o, .rx_flush_o, .tx_flush_o, .line_credit_o
  );

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] rx_q[$];
  logic [DW-1:0] tx_q[$];
  logic [8:0] ctrl_m = 9'h128;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven at the falling edge
  task automatic cycle();
    bit rx_on, tx_on, line_rx, line_tx, cpu_rx, cpu_tx, rx_req, tx_req;
    bit e_rx_push, e_tx_push, e_rx_ovf, e_tx_ovf, e_pop;
    logic [DW-1:0] e_rx_data, e_tx_data, e_rdata;
    int rx_free, tx_free, e_credit;
    rx_cnt_i  = CW'(rx_q.size());
    tx_cnt_i  = CW'(tx_q.size());
    rx_head_i = (rx_q.size() != 0) ? rx_q[0] : 8'hEE;
    #1;
    rx_on = ctrl_m[2] && !ctrl_m[3];
    tx_on = ctrl_m[4] && !ctrl_m[5];
    line_rx = !line_brk_i && line_vld_i && (mode_i == 0 || mode_i == 1);
    line_tx = !line_brk_i && line_vld_i && (mode_i == 1 || mode_i == 3);
    cpu_rx  = cpu_wr_i && mode_i == 2 && !line_brk_i;
    cpu_tx  = cpu_wr_i && mode_i == 0;
    rx_req  = line_brk_i || line_rx || cpu_rx;
    tx_req  = line_tx || cpu_tx;
    e_rx_data = line_brk_i ? 8'h00 : (line_rx ? line_data_i : cpu_wdata_i);
    e_tx_data = cpu_tx ? cpu_wdata_i : line_data_i;
    e_rx_push = rx_req && rx_on && rx_q.size() < RXD;
    e_rx_ovf  = rx_req && rx_on && rx_q.size() >= RXD;
    e_tx_push = tx_req && tx_on && tx_q.size() < TXD;
    e_tx_ovf  = tx_req && tx_on && tx_q.size() >= TXD;
    e_pop     = cpu_rd_i && rx_on && rx_q.size() != 0;
    e_rdata   = e_pop ? rx_q[0] : 8'h00;
    rx_free = RXD - rx_q.size();
    tx_free = TXD - tx_q.size();
    case (mode_i)
      2'd0: e_credit = rx_free;
      2'd1: e_credit = (rx_free < tx_free) ? rx_free : tx_free;
      2'd3: e_credit = tx_free;
      default: e_credit = 0;
    endcase

    chk("R1/R2/R3/R8", "rx_push", rx_push_o, e_rx_push);
    if (e_rx_push) chk("R1/R2/R8", "rx_push_data", rx_push_data_o, e_rx_data);
    chk("R1/R2/R3", "tx_push", tx_push_o, e_tx_push);
    if (e_tx_push) chk("R1/R2", "tx_push_data", tx_push_data_o, e_tx_data);
    chk("R4", "rx_ovf", rx_ovf_o, e_rx_ovf);
    chk("R5", "tx_ovf", tx_ovf_o, e_tx_ovf);
    chk("R6", "rx_pop", rx_pop_o, e_pop);
    if (cpu_rd_i) chk("R6", "cpu_rdata", cpu_rdata_o, e_rdata);
    chk("R7", "credit", line_credit_o, e_credit);
    chk("R9", "rx_flush", rx_flush_o, ctrl_m[0]);
    chk("R9", "tx_flush", tx_flush_o, ctrl_m[1]);
    chk("R9/R10", "ctrl", ctrl_o, ctrl_m);

    @(posedge clk);
    if (e_pop) void'(rx_q.pop_front());
    if (e_rx_push) rx_q.push_back(e_rx_data);
    if (e_tx_push) tx_q.push_back(e_tx_data);
    if (tx_q.size() != 0 && ($urandom % 5) == 0) void'(tx_q.pop_front());
    if (ctrl_m[0]) rx_q.delete();
    if (ctrl_m[1]) tx_q.delete();
    if (ctrl_we_i) ctrl_m = ctrl_wdata_i;
    else ctrl_m[1:0] = 2'b00;
    @(negedge clk);
  endtask

  task automatic quiet();
    ctrl_we_i = 1'b0; line_vld_i = 1'b0; line_brk_i = 1'b0;
    cpu_wr_i = 1'b0; cpu_rd_i = 1'b0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [8:0] en_set [6];
    en_set = '{9'h014, 9'h01C, 9'h034, 9'h014, 9'h004, 9'h010};
    // R10: reset state, paths off, line byte dropped
    mode_i = 2'd0; line_vld_i = 1'b1; line_data_i = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R10", "ctrl after reset", ctrl_o, 9'h128);
    chk("R10", "rx_push while off", rx_push_o, 1'b0);
    chk("R10", "flush after reset", {rx_flush_o, tx_flush_o}, 2'b00);
    rst_ni = 1'b1;
    quiet();
    cycle();
    // R9: flush both, pulse for one cycle
    ctrl_we_i = 1'b1; ctrl_wdata_i = 9'h017;
    cycle();
    quiet();
    cycle();
    cycle();
    for (int ph = 0; ph < 24; ph++) begin
      mode_i = 2'(ph % 4);
      ctrl_we_i = 1'b1; ctrl_wdata_i = en_set[(ph / 4) % 6];
      cycle();
      for (int c = 0; c < 150; c++) begin
        ctrl_we_i    = (($urandom % 40) == 0);
        ctrl_wdata_i = (ctrl_m & 9'h1FC) | 9'($urandom % 4);
        line_vld_i   = ($urandom % 2) == 0;
        line_data_i  = 8'($urandom);
        line_brk_i   = ($urandom % 10) == 0;
        cpu_wr_i     = ($urandom % 3) == 0;
        cpu_wdata_i  = 8'($urandom);
        cpu_rd_i     = ($urandom % 4) == 0;
        cycle();
      end
      quiet();
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule